// File: doc/BRIEF.md
# DMA Transfer Synchronization Controller

This block paces the read and write phases of a single DMA channel from interrupt events. A two-bit synchronization mode, taken from bits 7:6 of the channel control word, chooses which phases must wait for an interrupt. A unified/split select decides what those two bits mean. In unified operation one element is read and then written before the next element begins. In split operation the read side drains an input FIFO and the write side fills an output FIFO, and the two sides run independently of each other.

An interrupt line counts as an event for a side only when its bit is set in that side's enable mask. A pending event is held in a latch, and each latched event lets exactly one request through. The block issues one-cycle request strobes on a simple request/acknowledge handshake. Each side counts down its own copy of the word count, and a done flag rises once both sides have finished. Addressing, arbitration, the FIFOs and the interrupt controller are outside this block.

Top module: `dma_sync_ctrl`

## Requirements
- R1: A start pulse is accepted only while neither side is active. An accepted start captures `sync_mode` (bit 1 is control-word bit 7, bit 0 is bit 6), `split_mode` and `word_count`. A start that arrives while a side is active has no effect.
- R2: Mode 00 ignores every interrupt. Both sides issue requests without waiting, and in unified operation the requests alternate, read first.
- R3: Unified operation (`split_mode`=0). In mode 01 each read waits for a read event. In mode 10 each write waits for a write event. In mode 11 each read waits for a read event and each following write waits for a write event.
- R4: Split operation (`split_mode`=1). In mode 01 only the output-FIFO writes wait for a write event. In mode 10 only the input-FIFO reads wait for a read event. In mode 11 reads wait for read events and writes wait for write events, each side progressing on its own.
- R5: A read event is any `irq_lines` bit that is set in `rd_irq_mask`, and a write event likewise uses `wr_irq_mask`. Lines outside the mask have no effect. Events are latched only while that side is active, and an accepted start clears both latches, so events seen while idle are discarded.
- R6: One latched event releases exactly one gated request and then clears. An event that arrives in the same cycle as that release is kept for the next request.
- R7: `rd_req` and `wr_req` are registered pulses one cycle wide. Each rises on the clock edge after its release condition holds. A side issues no further request until its acknowledge has been sampled, and an acknowledge with no request outstanding is ignored.
- R8: In unified operation each element's write request comes after that element's read acknowledge, and the next read request comes only after the write acknowledge.
- R9: `done` is low after reset and is cleared by an accepted start. It rises one cycle after both sides have completed `word_count` transfers and stays high until the next accepted start. A count of zero issues no requests and raises `done` two edges after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request for a transfer block |
| split_mode | input | 1 | 0 = unified, 1 = split (input/output FIFO sides) |
| sync_mode | input | 2 | Synchronization mode field (control word bits 7:6) |
| rd_irq_mask | input | IRQ_W | Interrupt lines enabled as read-side events |
| wr_irq_mask | input | IRQ_W | Interrupt lines enabled as write-side events |
| irq_lines | input | IRQ_W | Raw level interrupt lines |
| word_count | input | CNT_W | Number of elements to move |
| rd_req | output | 1 | Read request strobe |
| rd_ack | input | 1 | Read acknowledge |
| wr_req | output | 1 | Write request strobe |
| wr_ack | input | 1 | Write acknowledge |
| done | output | 1 | Both sides finished |

## Verification
The hardest case to reach from the ports is a new event arriving in exactly the cycle in which a latched event is spent on a gated request. A second case of the same kind is a split mode 11 run in which both sides are parked waiting while acknowledges and interrupts interleave. Some runs drive the interrupt lines with dense random pulses, at up to ninety percent per line and cycle, with acknowledge latencies of zero to three cycles and stray acknowledges, so these collisions happen many times. A cycle-level reference model then flags any lost or doubled release. Directed sequences hold interrupts high while the block is idle, drive only masked-out lines, and pulse start during a run to reach the discard cases.

// File: rtl/dma_sync_pkg.sv
package dma_sync_pkg;

  // Side indices inside the per-side vectors
  localparam int SIDE_RD = 0;
  localparam int SIDE_WR = 1;
  localparam int NUM_SIDES = 2;

  typedef enum logic [1:0] {
    SIDE_IDLE = 2'd0,
    SIDE_WAIT = 2'd1,
    SIDE_BUSY = 2'd2
  } side_state_t;

  // Returns {write_gated, read_gated} for a mode field and operation kind.
  // Unified: bit0 gates reads, bit1 gates writes. Split swaps the meaning.
  function automatic logic [1:0] sync_gate_sel(input logic [1:0] mode,
                                               input logic split);
    logic [1:0] g;
    if (split) g = {mode[0], mode[1]};
    else       g = {mode[1], mode[0]};
    return g;
  endfunction

endpackage

// File: rtl/dma_sync_evt_latch.sv
module dma_sync_evt_latch (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic hit,
  input  logic arm,
  input  logic consume,
  output logic pending
);

  always_ff @(posedge clk) begin
    if (rst || clear) pending <= 1'b0;
    else              pending <= (pending & ~consume) | (hit & arm);
  end

endmodule

// File: rtl/dma_sync_side.sv
module dma_sync_side
  import dma_sync_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_acc,
  input  logic [CNT_W-1:0] count_in,
  input  logic             perm,
  input  logic             gate,
  input  logic             evt,
  input  logic             ack,
  output logic             req,
  output logic             consume,
  output logic             xfer,
  output logic             active,
  output logic             fin
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  side_state_t      st;
  logic [CNT_W-1:0] remain;
  logic             release_ok;

  always_comb begin
    release_ok = (st == SIDE_WAIT) && perm && (!gate || evt);
    consume    = (st == SIDE_WAIT) && perm && gate && evt;
    xfer       = (st == SIDE_BUSY) && ack;
    active     = (st != SIDE_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SIDE_IDLE;
      remain <= '0;
      req    <= 1'b0;
      fin    <= 1'b0;
    end else begin
      req <= release_ok;
      if (start_acc) begin
        remain <= count_in;
        if (count_in == '0) begin
          st  <= SIDE_IDLE;
          fin <= 1'b1;
        end else begin
          st  <= SIDE_WAIT;
          fin <= 1'b0;
        end
      end else begin
        case (st)
          SIDE_WAIT: if (release_ok) st <= SIDE_BUSY;
          SIDE_BUSY: begin
            if (ack) begin
              remain <= remain - ONE;
              if (remain == ONE) begin
                st  <= SIDE_IDLE;
                fin <= 1'b1;
              end else begin
                st <= SIDE_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dma_sync_ctrl.sv
module dma_sync_ctrl
  import dma_sync_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             split_mode,
  input  logic [1:0]       sync_mode,
  input  logic [IRQ_W-1:0] rd_irq_mask,
  input  logic [IRQ_W-1:0] wr_irq_mask,
  input  logic [IRQ_W-1:0] irq_lines,
  input  logic [CNT_W-1:0] word_count,
  output logic             rd_req,
  input  logic             rd_ack,
  output logic             wr_req,
  input  logic             wr_ack,
  output logic             done
);

  logic [1:0]           mode_q;
  logic                 split_q;
  logic                 token_q;
  logic                 busy;
  logic                 start_acc;
  logic [NUM_SIDES-1:0] side_hit, side_perm, side_gate, side_evt, side_consume;
  logic [NUM_SIDES-1:0] side_xfer, side_active, side_fin, side_req, side_ack;

  always_comb begin
    busy      = |side_active;
    start_acc = start && !busy;
    side_hit[SIDE_RD] = |(irq_lines & rd_irq_mask);
    side_hit[SIDE_WR] = |(irq_lines & wr_irq_mask);
    side_ack[SIDE_RD] = rd_ack;
    side_ack[SIDE_WR] = wr_ack;
    side_gate = sync_gate_sel(mode_q, split_q);
    // Unified: the token holds a read element that still needs its write
    side_perm = split_q ? {NUM_SIDES{1'b1}} : {token_q, ~token_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= 2'b00;
      split_q <= 1'b0;
      token_q <= 1'b0;
      done    <= 1'b0;
    end else begin
      if (start_acc) begin
        mode_q  <= sync_mode;
        split_q <= split_mode;
      end
      if (start_acc)              token_q <= 1'b0;
      else if (side_xfer[SIDE_RD]) token_q <= 1'b1;
      else if (side_xfer[SIDE_WR]) token_q <= 1'b0;
      done <= start_acc ? 1'b0 : &side_fin;
    end
  end

  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
    dma_sync_evt_latch u_latch (
      .clk     (clk),
      .rst     (rst),
      .clear   (start_acc),
      .hit     (side_hit[g]),
      .arm     (side_active[g]),
      .consume (side_consume[g]),
      .pending (side_evt[g])
    );

    dma_sync_side #(.CNT_W(CNT_W)) u_side (
      .clk       (clk),
      .rst       (rst),
      .start_acc (start_acc),
      .count_in  (word_count),
      .perm      (side_perm[g]),
      .gate      (side_gate[g]),
      .evt       (side_evt[g]),
      .ack       (side_ack[g]),
      .req       (side_req[g]),
      .consume   (side_consume[g]),
      .xfer      (side_xfer[g]),
      .active    (side_active[g]),
      .fin       (side_fin[g])
    );
  end

  assign rd_req = side_req[SIDE_RD];
  assign wr_req = side_req[SIDE_WR];

endmodule

// File: rtl/dma_sync_ctrl_chk.sv
module dma_sync_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       split_q,
  input logic [1:0] mode_q,
  input logic [1:0] side_gate,
  input logic [1:0] side_evt,
  input logic       rd_req,
  input logic       wr_req,
  input logic       done
);

  a_r7_rd_single: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  a_r7_wr_single: assert property (@(posedge clk) disable iff (rst)
    wr_req |=> !wr_req);

  // R3 / R4: a gated read or write is released only by a latched event
  a_r3_rd_needs_evt: assert property (@(posedge clk) disable iff (rst)
    (rd_req && side_gate[0]) |-> $past(side_evt[0]));

  a_r4_wr_needs_evt: assert property (@(posedge clk) disable iff (rst)
    (wr_req && side_gate[1]) |-> $past(side_evt[1]));

  a_r8_unified_exclusive: assert property (@(posedge clk) disable iff (rst)
    !split_q |-> !(rd_req && wr_req));

  a_r1_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> $stable(mode_q) && $stable(split_q));

  a_r9_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  a_r9_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> (!rd_req && !wr_req));

endmodule

bind dma_sync_ctrl dma_sync_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .split_q   (split_q),
  .mode_q    (mode_q),
  .side_gate (side_gate),
  .side_evt  (side_evt),
  .rd_req    (rd_req),
  .wr_req    (wr_req),
  .done      (done)
);

// File: tb/tb_dma_sync_ctrl.sv
module tb_dma_sync_ctrl;

  localparam int CNT_W = 16;
  localparam int IRQ_W = 4;

  logic             clk = 1'b0;
  logic             rst;
  logic             start;
  logic             split_mode;
  logic [1:0]       sync_mode;
  logic [IRQ_W-1:0] rd_irq_mask, wr_irq_mask, irq_lines;
  logic [CNT_W-1:0] word_count;
  logic             rd_req, rd_ack, wr_req, wr_ack, done;

  always #2 clk = ~clk;

  dma_sync_ctrl #(.CNT_W(CNT_W), .IRQ_W(IRQ_W)) dut (
    .clk(clk), .rst(rst), .start(start), .split_mode(split_mode),
    .sync_mode(sync_mode), .rd_irq_mask(rd_irq_mask), .wr_irq_mask(wr_irq_mask),
    .irq_lines(irq_lines), .word_count(word_count), .rd_req(rd_req),
    .rd_ack(rd_ack), .wr_req(wr_req), .wr_ack(wr_ack), .done(done)
  );

  int    n_chk = 0, n_bad = 0, cycles = 0;
  int    cnt_rd = 0, cnt_wr = 0;
  int    irq_dens = 0, rd_lat = 0, wr_lat = 0;
  int    rd_cd = 0, wr_cd = 0;
  bit    rd_out = 0, wr_out = 0, spur = 0, irq_hold = 0, finished = 0;
  logic [IRQ_W-1:0] irq_fixed = '0;
  string cur_tag = "R7";

  // ---------------- reference model ----------------
  int   m_st[2], m_rem[2];
  bit   m_fin[2], m_evt[2], m_req[2];
  bit   m_tok, m_split, m_done;
  logic [1:0] m_mode;
  bit   t_sa, t_hit[2], t_ack[2], t_perm[2], t_gate[2], t_iss[2], t_con[2], t_xf[2];

  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < 2; s++) begin
        m_st[s] = 0; m_rem[s] = 0; m_fin[s] = 0; m_evt[s] = 0; m_req[s] = 0;
      end
      m_tok = 0; m_split = 0; m_done = 0; m_mode = 2'b00;
    end else begin
      t_sa = start && m_st[0] == 0 && m_st[1] == 0;
      t_hit[0] = |(irq_lines & rd_irq_mask);
      t_hit[1] = |(irq_lines & wr_irq_mask);
      t_ack[0] = rd_ack; t_ack[1] = wr_ack;
      t_perm[0] = m_split ? 1'b1 : !m_tok;
      t_perm[1] = m_split ? 1'b1 : m_tok;
      t_gate[0] = m_split ? m_mode[1] : m_mode[0];
      t_gate[1] = m_split ? m_mode[0] : m_mode[1];
      for (int s = 0; s < 2; s++) begin
        t_iss[s] = m_st[s] == 1 && t_perm[s] && (!t_gate[s] || m_evt[s]);
        t_con[s] = m_st[s] == 1 && t_perm[s] && t_gate[s] && m_evt[s];
        t_xf[s]  = m_st[s] == 2 && t_ack[s];
      end
      m_done = t_sa ? 1'b0 : (m_fin[0] && m_fin[1]);
      if (t_sa) m_tok = 0;
      else if (t_xf[0]) m_tok = 1;
      else if (t_xf[1]) m_tok = 0;
      if (t_sa) begin m_mode = sync_mode; m_split = split_mode; end
      for (int s = 0; s < 2; s++) begin
        m_req[s] = t_iss[s];
        m_evt[s] = t_sa ? 1'b0 : ((m_evt[s] && !t_con[s]) || (t_hit[s] && m_st[s] != 0));
        if (t_sa) begin
          m_rem[s] = int'(word_count);
          if (word_count == 0) begin m_st[s] = 0; m_fin[s] = 1; end
          else begin m_st[s] = 1; m_fin[s] = 0; end
        end else if (m_st[s] == 1 && t_iss[s]) begin
          m_st[s] = 2;
        end else if (t_xf[s]) begin
          m_rem[s]--;
          if (m_rem[s] == 0) begin m_st[s] = 0; m_fin[s] = 1; end
          else m_st[s] = 1;
        end
      end
    end
  end

  // ---------------- compare, responders, stimulus ----------------
  always @(negedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R9: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
    if (!rst) begin
      n_chk++;
      if (rd_req !== m_req[0] || wr_req !== m_req[1] || done !== m_done) begin
        n_bad++;
        $display("FAIL %s cycle %0d: actual rd=%b wr=%b done=%b expected rd=%b wr=%b done=%b",
                 cur_tag, cycles, rd_req, wr_req, done, m_req[0], m_req[1], m_done);
      end
      if (rd_req) cnt_rd++;
      if (wr_req) begin
        if (!m_split) begin
          n_chk++;  // R8: write follows its own read
          if (cnt_rd != cnt_wr + 1) begin
            n_bad++;
            $display("FAIL R8: actual reads=%0d expected reads=%0d at write", cnt_rd, cnt_wr + 1);
          end
        end
        cnt_wr++;
      end
    end
    rd_ack = 1'b0;
    if (rd_cd > 0) begin
      rd_cd--;
      if (rd_cd == 0) begin rd_ack = 1'b1; rd_out = 0; end
    end
    if (rd_req) begin
      rd_out = 1;
      if (rd_lat == 0) begin rd_ack = 1'b1; rd_out = 0; end
      else rd_cd = rd_lat;
    end
    if (spur && !rd_out && !rd_req && $urandom_range(3) == 0) rd_ack = 1'b1;
    wr_ack = 1'b0;
    if (wr_cd > 0) begin
      wr_cd--;
      if (wr_cd == 0) begin wr_ack = 1'b1; wr_out = 0; end
    end
    if (wr_req) begin
      wr_out = 1;
      if (wr_lat == 0) begin wr_ack = 1'b1; wr_out = 0; end
      else wr_cd = wr_lat;
    end
    if (spur && !wr_out && !wr_req && $urandom_range(3) == 0) wr_ack = 1'b1;
    if (irq_hold) irq_lines = irq_fixed;
    else for (int b = 0; b < IRQ_W; b++) irq_lines[b] = ($urandom_range(99) < irq_dens);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start(input bit sp, input logic [7:0] ctrl, input int cnt);
    @(negedge clk);
    split_mode = sp;
    sync_mode  = ctrl[7:6];
    word_count = CNT_W'(cnt);
    if (!dut.busy) begin cnt_rd = 0; cnt_wr = 0; end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag, input int exp_cnt);
    int w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    check(done === 1'b1, {tag, " done"}, int'(done), 1);
    check(cnt_rd == exp_cnt, {tag, " reads"}, cnt_rd, exp_cnt);
    check(cnt_wr == exp_cnt, {tag, " writes"}, cnt_wr, exp_cnt);
  endtask

  task automatic run_case(input bit sp, input logic [1:0] md, input int cnt, input int dens,
                          input int rl, input int wl, input bit sa, input string tag);
    irq_dens = dens; rd_lat = rl; wr_lat = wl; spur = sa; irq_hold = 0; cur_tag = tag;
    pulse_start(sp, {md, 6'b0}, cnt);
    wait_done(tag, cnt);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; split_mode = 1'b0; sync_mode = 2'b00;
    rd_irq_mask = 4'b0011; wr_irq_mask = 4'b1100; irq_lines = '0;
    word_count = '0; rd_ack = 1'b0; wr_ack = 1'b0;
    repeat (4) @(negedge clk);
    check(rd_req === 1'b0 && wr_req === 1'b0, "R7 reset strobes", int'(rd_req | wr_req), 0);
    check(done === 1'b0, "R9 reset done", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);

    run_case(0, 2'b00, 5, 60, 0, 0, 0, "R2");
    run_case(0, 2'b01, 4, 10, 1, 2, 0, "R3");
    run_case(0, 2'b10, 4, 10, 2, 0, 1, "R3");
    run_case(0, 2'b11, 6, 15, 0, 1, 1, "R8");
    run_case(1, 2'b01, 5, 10, 0, 3, 0, "R4");
    run_case(1, 2'b10, 5, 10, 1, 0, 1, "R4");
    run_case(1, 2'b11, 7, 20, 0, 0, 0, "R4");
    run_case(1, 2'b11, 9, 90, 0, 0, 1, "R6");
    run_case(0, 2'b11, 9, 90, 0, 1, 0, "R6");
    run_case(1, 2'b00, 3, 0, 2, 2, 1, "R7");
    run_case(0, 2'b11, 0, 0, 0, 0, 0, "R9");

    // R5: events while idle are discarded, masked-out lines do nothing
    cur_tag = "R5"; irq_hold = 1; irq_fixed = 4'hF; rd_lat = 1; wr_lat = 1; spur = 0;
    repeat (10) @(negedge clk);
    irq_fixed = 4'h0;
    pulse_start(0, 8'b01_000000, 2);
    repeat (20) @(negedge clk);
    check(cnt_rd == 0, "R5 idle events discarded", cnt_rd, 0);
    irq_fixed = 4'b1000;
    repeat (15) @(negedge clk);
    check(cnt_rd == 0, "R5 masked line ignored", cnt_rd, 0);
    irq_hold = 0; irq_dens = 20;
    wait_done("R5", 2);

    // R1: start while busy is ignored
    cur_tag = "R1"; irq_dens = 0;
    pulse_start(0, 8'b11_000000, 3);
    repeat (5) @(negedge clk);
    pulse_start(1, 8'b00_000000, 9);
    repeat (10) @(negedge clk);
    check(cnt_rd == 0, "R1 busy start ignored", cnt_rd, 0);
    irq_dens = 25;
    wait_done("R1", 3);

    // R9: done holds until the next start
    cur_tag = "R9"; irq_dens = 30;
    repeat (6) @(negedge clk);
    check(done === 1'b1, "R9 done holds", int'(done), 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule